// File: doc/BRIEF.md
# Banked Upper-Memory Address Translator

This block steers each CPU memory access of an 8-bit, 16-bit-address system onto its backing stores. Three stores sit behind it: a 12 KB ROM, a 68 KB main RAM and an auxiliary RAM. Four bank flags come from elsewhere in the system:

- the RAM-read select,
- the write-enable,
- the bank-2 select,
- the alternate zero-page select.

The block combines these flags with the address and the access direction. From them it decides whether the access goes to ROM, to RAM or nowhere, and it produces the physical address for the chosen store.

The translation of addresses 0xD000 to 0xFFFF is banked. ROM reads in this window are rebased to start at ROM address zero. With bank 2 selected, the 4 KB region from 0xD000 to 0xDFFF is relocated by +0x3000, so it lands in the 64 to 68 KB range of main RAM.

Outside the window, the zero-page and stack pages (0x0000 to 0x01FF) can be redirected to auxiliary RAM. Every other address passes straight through to main RAM. The result is registered once, so each decision reaches the RAM and ROM ports one clock after the request is sampled.

Top module: `upmem_xlate`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every output is 0.
- R2: A valid read at 0xD000 or above with `sel_ram_read` low asserts `rom_rd_o` with `rom_addr_o` = address − 0xD000. `ram_en_o` stays 0. This holds regardless of `sel_bank2`.
- R3: A valid read at 0xD000 to 0xDFFF with `sel_ram_read` and `sel_bank2` high asserts `ram_en_o`, with `ram_addr_o` = address + 0x3000 (0x10000 to 0x10FFF).
- R4: A valid read in the window with `sel_ram_read` high gives `ram_addr_o` = address in two cases: `sel_bank2` is low, or the address is 0xE000 or above.
- R5: A valid write at 0xD000 or above with `sel_write_en` low drives `ram_en_o`, `ram_we_o` and `rom_rd_o` all to 0. `rom_rd_o` is never asserted for a write.
- R6: A valid write in the window with `sel_write_en` high asserts `ram_en_o` and `ram_we_o`, using the same bank-2 relocation as reads. The value of `sel_ram_read` has no effect on this.
- R7: A valid access at 0x0000 to 0x01FF goes to RAM at the unchanged address. `ram_aux_o` equals `sel_alt_zp`.
- R8: A valid access at 0x0200 to 0xCFFF goes to main RAM at the unchanged address, with `ram_aux_o` = 0 and `ram_we_o` = `req_write`. The bank flags have no effect on it.
- R9: When `req_valid` is low, all enables are 0. Both address outputs are 0 whenever their own enable is 0.
- R10: Outputs change exactly one clock edge after the request is sampled, and hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access is present this cycle |
| req_addr | input | 16 | CPU address |
| req_write | input | 1 | 1 = write, 0 = read |
| sel_ram_read | input | 1 | Window reads come from RAM instead of ROM |
| sel_write_en | input | 1 | Window writes are permitted |
| sel_bank2 | input | 1 | 0xD000–0xDFFF uses the relocated bank 2 |
| sel_alt_zp | input | 1 | Zero page and stack come from auxiliary RAM |
| rom_rd_o | output | 1 | ROM read strobe |
| rom_addr_o | output | 14 | ROM address |
| ram_en_o | output | 1 | RAM access strobe |
| ram_we_o | output | 1 | RAM write enable |
| ram_aux_o | output | 1 | 1 = auxiliary RAM, 0 = main RAM |
| ram_addr_o | output | 17 | RAM physical address |

## Verification
The bench builds the translator with its default parameters: a 16-bit address, a 17-bit physical RAM address, a 14-bit ROM address, the window at 0xD000, the bank split at 0xE000, the +0x3000 relocation and a 0x0200 zero-page limit. These values put every edge of the map within reach of a directed access:

- the first and last bytes of the relocated bank (0x10000 and 0x10FFF);
- the top ROM byte (0x2FFF);
- the addresses on either side of the bank split (0xDFFF and 0xE000);
- the addresses on either side of the zero-page limit (0x01FF and 0x0200).

// File: rtl/upx_pkg.sv
package upx_pkg;
  typedef enum logic [1:0] {
    RGN_PLAIN  = 2'd0,
    RGN_ZPSTK  = 2'd1,
    RGN_WINDOW = 2'd2
  } upx_region_e;
endpackage

// File: rtl/upx_region_dec.sv
module upx_region_dec
  import upx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'hD000,
  parameter logic [ADDR_W-1:0] SPLIT = 'hE000,
  parameter logic [ADDR_W-1:0] ZP_LIMIT = 'h0200
) (
  input  logic [ADDR_W-1:0] addr,
  output upx_region_e       region,
  output logic              lo_half
);
  always_comb begin
    if (addr >= WIN_BASE) region = RGN_WINDOW;
    else if (addr < ZP_LIMIT) region = RGN_ZPSTK;
    else region = RGN_PLAIN;
  end

  // Only the part of the window below the split can be banked.
  assign lo_half = (addr < SPLIT);
endmodule

// File: rtl/upx_window_map.sv
module upx_window_map #(
  parameter int ADDR_W = 16,
  parameter int PHYS_W = 17,
  parameter int ROM_AW = 14,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'hD000,
  parameter logic [PHYS_W-1:0] BANK2_OFS = 'h3000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  input  logic              lo_half,
  input  logic              ram_rd,
  input  logic              wr_en,
  input  logic              bank2,
  output logic              rom_rd,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              ram_en,
  output logic              ram_we,
  output logic [PHYS_W-1:0] ram_addr
);
  logic [PHYS_W-1:0] flat_addr;
  logic [PHYS_W-1:0] reloc_addr;
  logic [ROM_AW-1:0] rebased;
  logic              use_bank2;

  assign flat_addr  = PHYS_W'(addr);
  assign reloc_addr = flat_addr + BANK2_OFS;
  assign rebased    = ROM_AW'(addr - WIN_BASE);
  assign use_bank2  = lo_half & bank2;

  always_comb begin
    rom_rd   = 1'b0;
    rom_addr = '0;
    ram_en   = 1'b0;
    ram_we   = 1'b0;
    ram_addr = '0;
    if (is_write) begin
      // Write steering ignores the read source; ROM never sees a write.
      if (wr_en) begin
        ram_en   = 1'b1;
        ram_we   = 1'b1;
        ram_addr = use_bank2 ? reloc_addr : flat_addr;
      end
    end else if (!ram_rd) begin
      rom_rd   = 1'b1;
      rom_addr = rebased;
    end else begin
      ram_en   = 1'b1;
      ram_addr = use_bank2 ? reloc_addr : flat_addr;
    end
  end
endmodule

// File: rtl/upx_out_stage.sv
module upx_out_stage #(
  parameter int W = 35,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else q <= d;
      end
    end else begin : g_thru
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/upmem_xlate.sv
module upmem_xlate
  import upx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PHYS_W = 17,
  parameter int ROM_AW = 14,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'hD000,
  parameter logic [ADDR_W-1:0] SPLIT = 'hE000,
  parameter logic [ADDR_W-1:0] ZP_LIMIT = 'h0200,
  parameter logic [PHYS_W-1:0] BANK2_OFS = 'h3000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              sel_ram_read,
  input  logic              sel_write_en,
  input  logic              sel_bank2,
  input  logic              sel_alt_zp,
  output logic              rom_rd_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic              ram_aux_o,
  output logic [PHYS_W-1:0] ram_addr_o
);
  localparam int OUT_W = 1 + ROM_AW + 3 + PHYS_W;
  localparam logic [PHYS_W-1:0] BANK_SPAN = PHYS_W'(SPLIT - WIN_BASE);
  localparam logic [PHYS_W-1:0] HI_BASE = PHYS_W'(1) << ADDR_W;
  localparam logic [PHYS_W-1:0] HI_TOP = HI_BASE + BANK_SPAN;

  upx_region_e region;
  logic        lo_half;

  logic              w_rom_rd, w_ram_en, w_ram_we;
  logic [ROM_AW-1:0] w_rom_addr;
  logic [PHYS_W-1:0] w_ram_addr;

  logic              n_rom_rd, n_ram_en, n_ram_we, n_ram_aux;
  logic [ROM_AW-1:0] n_rom_addr;
  logic [PHYS_W-1:0] n_ram_addr;
  logic [OUT_W-1:0]  next_vec, out_vec;

  upx_region_dec #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .SPLIT(SPLIT), .ZP_LIMIT(ZP_LIMIT)
  ) region_i (
    .addr(req_addr), .region(region), .lo_half(lo_half)
  );

  upx_window_map #(
    .ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .ROM_AW(ROM_AW),
    .WIN_BASE(WIN_BASE), .BANK2_OFS(BANK2_OFS)
  ) window_i (
    .addr(req_addr), .is_write(req_write), .lo_half(lo_half),
    .ram_rd(sel_ram_read), .wr_en(sel_write_en), .bank2(sel_bank2),
    .rom_rd(w_rom_rd), .rom_addr(w_rom_addr), .ram_en(w_ram_en),
    .ram_we(w_ram_we), .ram_addr(w_ram_addr)
  );

  always_comb begin
    n_rom_rd   = 1'b0;
    n_rom_addr = '0;
    n_ram_en   = 1'b0;
    n_ram_we   = 1'b0;
    n_ram_aux  = 1'b0;
    n_ram_addr = '0;
    if (req_valid) begin
      unique case (region)
        RGN_WINDOW: begin
          n_rom_rd   = w_rom_rd;
          n_rom_addr = w_rom_addr;
          n_ram_en   = w_ram_en;
          n_ram_we   = w_ram_we;
          n_ram_addr = w_ram_addr;
        end
        RGN_ZPSTK: begin
          n_ram_en   = 1'b1;
          n_ram_we   = req_write;
          n_ram_aux  = sel_alt_zp;
          n_ram_addr = PHYS_W'(req_addr);
        end
        default: begin
          n_ram_en   = 1'b1;
          n_ram_we   = req_write;
          n_ram_addr = PHYS_W'(req_addr);
        end
      endcase
    end
  end

  assign next_vec = {n_rom_rd, n_rom_addr, n_ram_en, n_ram_we, n_ram_aux, n_ram_addr};

  upx_out_stage #(.W(OUT_W), .OUT_REG(1'b1)) out_i (
    .clk(clk), .rst(rst), .d(next_vec), .q(out_vec)
  );

  assign {rom_rd_o, rom_addr_o, ram_en_o, ram_we_o, ram_aux_o, ram_addr_o} = out_vec;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    !(rom_rd_o && ram_en_o)); // R2
  AST_BANK2_SPAN: assert property (@(posedge clk) disable iff (rst)
    (ram_addr_o >= HI_BASE) |-> (ram_en_o && ram_addr_o < HI_TOP && !ram_aux_o)); // R3
  AST_NO_ROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> !rom_rd_o); // R5
  AST_WIN_WR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr >= WIN_BASE && !sel_write_en) |=> !ram_en_o); // R5
  AST_WE_HAS_EN: assert property (@(posedge clk) disable iff (rst)
    ram_we_o |-> ram_en_o); // R6
  AST_AUX_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
    ram_aux_o |-> (ram_en_o && ram_addr_o < PHYS_W'(ZP_LIMIT))); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!ram_en_o && !rom_rd_o && ram_addr_o == '0 && rom_addr_o == '0)); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid) == 1'b0 && !req_valid) |=> $stable(out_vec)); // R10
endmodule

// File: tb/upmem_xlate_tb_top.sv
module upmem_xlate_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic req_write = 1'b0;
  logic sel_ram_read = 1'b0, sel_write_en = 1'b0, sel_bank2 = 1'b0, sel_alt_zp = 1'b0;
  logic rom_rd_o, ram_en_o, ram_we_o, ram_aux_o;
  logic [13:0] rom_addr_o;
  logic [16:0] ram_addr_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  upmem_xlate dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .sel_ram_read(sel_ram_read), .sel_write_en(sel_write_en),
    .sel_bank2(sel_bank2), .sel_alt_zp(sel_alt_zp), .rom_rd_o(rom_rd_o),
    .rom_addr_o(rom_addr_o), .ram_en_o(ram_en_o), .ram_we_o(ram_we_o),
    .ram_aux_o(ram_aux_o), .ram_addr_o(ram_addr_o)
  );

  function automatic logic [34:0] actual_vec();
    return {rom_rd_o, rom_addr_o, ram_en_o, ram_we_o, ram_aux_o, ram_addr_o};
  endfunction

  function automatic logic [34:0] model(input logic v, input logic [15:0] a, input logic w,
                                        input logic rr, input logic we, input logic b2,
                                        input logic az);
    logic rom = 0, en = 0, wren = 0, aux = 0;
    logic [13:0] ra = '0;
    logic [16:0] pa = '0;
    logic [16:0] pick;
    pick = (a < 16'hE000 && b2) ? {1'b0, a} + 17'h03000 : {1'b0, a};
    if (v) begin
      if (a >= 16'hD000) begin
        if (w) begin
          if (we) begin en = 1; wren = 1; pa = pick; end
        end else if (!rr) begin
          rom = 1; ra = 14'(a - 16'hD000);
        end else begin
          en = 1; pa = pick;
        end
      end else begin
        en = 1; wren = w; aux = (a < 16'h0200) && az; pa = {1'b0, a};
      end
    end
    return {rom, ra, en, wren, aux, pa};
  endfunction

  task automatic check(input string tag, input logic [34:0] exp);
    checks++;
    if (actual_vec() !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, actual_vec(), exp);
    end
  endtask

  task automatic access(input string tag, input logic v, input logic [15:0] a, input logic w,
                        input logic rr, input logic we, input logic b2, input logic az);
    @(negedge clk);
    req_valid = v; req_addr = a; req_write = w;
    sel_ram_read = rr; sel_write_en = we; sel_bank2 = b2; sel_alt_zp = az;
    @(posedge clk); #1;
    check(tag, model(v, a, w, rr, we, b2, az));
  endtask

  task automatic t_reset();
    rst = 1'b1; req_valid = 1'b1; req_addr = 16'h8000;
    repeat (3) @(posedge clk);
    #1 check("R1 during reset", '0);
    @(negedge clk); rst = 1'b0; req_valid = 1'b0;
    @(posedge clk); #1 check("R1 after reset", '0);
  endtask

  task automatic t_idle();
    access("R9 idle window", 0, 16'hD123, 0, 1, 1, 1, 1);
    access("R9 idle zp", 0, 16'h0010, 1, 0, 0, 0, 1);
  endtask

  task automatic t_rom_read();
    access("R2 rom base", 1, 16'hD000, 0, 0, 0, 0, 0);
    access("R2 rom top", 1, 16'hFFFF, 0, 0, 0, 0, 0);
    access("R2 rom mid", 1, 16'hE123, 0, 0, 1, 0, 0);
    access("R2 rom bank2 ignored", 1, 16'hD005, 0, 0, 1, 1, 1);
  endtask

  task automatic t_bank2_read();
    access("R3 bank2 first", 1, 16'hD000, 0, 1, 0, 1, 0);
    access("R3 bank2 last", 1, 16'hDFFF, 0, 1, 0, 1, 0);
  endtask

  task automatic t_plain_window_read();
    access("R4 bank1 D", 1, 16'hD456, 0, 1, 0, 0, 0);
    access("R4 bank2 E split", 1, 16'hE000, 0, 1, 0, 1, 0);
    access("R4 bank2 top", 1, 16'hFFFF, 0, 1, 1, 1, 0);
  endtask

  task automatic t_write_blocked();
    access("R5 write off rom mode", 1, 16'hD010, 1, 0, 0, 1, 0);
    access("R5 write off ram mode", 1, 16'hF000, 1, 1, 0, 0, 1);
  endtask

  task automatic t_write_allowed();
    access("R6 write bank2 rom reads", 1, 16'hD010, 1, 0, 1, 1, 0);
    access("R6 write bank1", 1, 16'hD010, 1, 1, 1, 0, 0);
    access("R6 write upper", 1, 16'hE800, 1, 0, 1, 1, 0);
  endtask

  task automatic t_zero_page();
    access("R7 zp aux", 1, 16'h0000, 0, 0, 0, 0, 1);
    access("R7 stack top aux", 1, 16'h01FF, 1, 0, 0, 0, 1);
    access("R7 zp main", 1, 16'h0042, 1, 0, 0, 0, 0);
  endtask

  task automatic t_pass_through();
    access("R8 above stack", 1, 16'h0200, 0, 1, 1, 1, 1);
    access("R8 below window write", 1, 16'hCFFF, 1, 0, 0, 1, 1);
    access("R8 mid read", 1, 16'h8000, 0, 1, 1, 1, 0);
  endtask

  task automatic t_latency();
    logic [34:0] prev;
    access("R10 first", 1, 16'h1234, 0, 0, 0, 0, 0);
    prev = model(1, 16'h1234, 0, 0, 0, 0, 0);
    @(negedge clk);
    req_addr = 16'hD000; sel_ram_read = 1'b1; sel_bank2 = 1'b1;
    #1 check("R10 held before edge", prev);
    @(posedge clk); #1;
    check("R10 after edge", model(1, 16'hD000, 0, 1, 0, 1, 0));
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_rom_read();
    t_bank2_read();
    t_plain_window_read();
    t_write_blocked();
    t_write_allowed();
    t_zero_page();
    t_pass_through();
    t_latency();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule